// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block is the receive side of an I2C target inside a bus controller. A front end that already decodes the wire delivers one event per cycle: start, address byte, data byte or stop. The engine compares the address byte with a programmable 7-bit own address. When the address matches and the request is a write, each data byte goes out through a byte-wide memory write port. The write address comes from a counter that counts up from a programmed base, and a remaining-length counter counts down to zero. A received-byte count is cleared at the start of every addressed transfer.

A normal stop closes the transfer and sets a group of status bits in one cycle. Software clears the whole group by writing one bit. When receive DMA is off, the engine works in a byte-buffer mode and puts the address byte and then each data byte into a register that software can read. A master-side status register shares the single interrupt line with the target status. The line is a registered OR of enabled status from both registers, so a source that is still pending keeps the line high after the other source is cleared.

The register interface is word-indexed (`reg_addr_i`) and reads combinationally. Writes take effect at the clock edge where `reg_we_i` is high.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: After reset, the status, enable, counter and buffer registers read zero, `irq_o` is low and `mem_we_o` is low.
- R2: An address byte after a start opens a transfer only when bits [7:1] equal the own address and bit 0 is 0. A mismatched address or a read request (bit 0 = 1) is ignored until the next start: no memory write and no status change.
- R3: The received-byte count (length register bits [16+LW-1:16]) is set to zero when an addressed write transfer opens.
- R4: With receive DMA on, each data byte of an open transfer is written at the address counter on `mem_addr_o` one cycle after the event. The address counter then goes up by one, the remaining count (length register bits [LW-1:0]) goes down by one and the received count goes up by one. Register index 3 reads back the current address counter.
- R5: With receive DMA on and a remaining count of zero, a data byte is dropped with no memory write, and target status bit 5 (overflow) is set.
- R6: A stop that ends an open transfer sets target status bits 4 (packet done), 2 (address matched), 1 (stop seen) and 0 (receive) in the same cycle.
- R7: Writing a 1 to target status bit 4 clears bits [4:0] and leaves bit 5 unchanged. A 1 written to any other status bit clears only that bit.
- R8: A write to the length register (index 4) always loads the remaining count from bits [LW-1:0]. It loads the received count from bits [16+LW-1:16] only when bit 31 of the written data is 1.
- R9: With receive DMA off (index 2 bit 0 = 0), an address match puts own address shifted left by one, with bit 0 = 0, into the byte buffer (index 9). Each later data byte replaces the buffer contents. Each of these events sets target status bit 3, and no memory write takes place.
- R10: `irq_o` goes high one cycle after (target status AND target enable) or (master status AND master enable) is non-zero, and goes low one cycle after both are zero. Target status is index 5, target enable index 6, master status index 7 and master enable index 8.
- R11: A pulse on `mst_set_i` sets the matching master status bits only while master enable (index 0 bit 0) is 1. Writing a 1 to a master status bit clears it.
- R12: Register map: index 0 holds function control (bit 0 master enable, bit 1 target enable), index 1 holds the own address in [6:0] and index 2 bit 0 enables receive DMA. With target enable 0, every address byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| ev_valid_i | input | 1 | Bus event present this cycle |
| ev_kind_i | input | 2 | Event kind: 0 start, 1 address, 2 data, 3 stop |
| ev_data_i | input | 8 | Byte carried by address and data events |
| mst_set_i | input | MW | Master-side status set pulses |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| irq_o | output | 1 | Shared interrupt, registered |

## Verification
The hardest case to reach is two interrupt sources pending at the same time, where clearing one of them must leave the line high. The stimulus pulses master status and then completes a target transfer before it clears either source. It then repeats the sequence in the opposite order. Buffer exhaustion is reached by programming a remaining count of one and sending two bytes, so that a dropped byte and its overflow bit are both visible before the packet-done clear.

// File: rtl/tgt_rx_pkg.sv
package tgt_rx_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_ADDR  = 2'd1,
    EV_DATA  = 2'd2,
    EV_STOP  = 2'd3
  } bus_ev_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_ADDR,
    ST_ACTIVE
  } rx_state_e;

  localparam int STS_W     = 6;
  localparam int B_RX      = 0;
  localparam int B_STOP    = 1;
  localparam int B_MATCH   = 2;
  localparam int B_BYTE    = 3;
  localparam int B_PKT     = 4;
  localparam int B_OVF     = 5;

  localparam logic [3:0] RI_FUNC = 4'd0;
  localparam logic [3:0] RI_OWN  = 4'd1;
  localparam logic [3:0] RI_CMD  = 4'd2;
  localparam logic [3:0] RI_BASE = 4'd3;
  localparam logic [3:0] RI_LEN  = 4'd4;
  localparam logic [3:0] RI_TSTS = 4'd5;
  localparam logic [3:0] RI_TIEN = 4'd6;
  localparam logic [3:0] RI_MSTS = 4'd7;
  localparam logic [3:0] RI_MIEN = 4'd8;
  localparam logic [3:0] RI_BUF  = 4'd9;

  localparam int LEN_HI_LSB = 16;
  localparam int LEN_WE_BIT = 31;
endpackage

// File: rtl/tgt_rx_dma.sv
module tgt_rx_dma
  import tgt_rx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic [1:0]       ev_kind_i,
  input  logic [7:0]       ev_data_i,
  input  logic             target_en_i,
  input  logic             dma_en_i,
  input  logic [6:0]       own_addr_i,
  input  logic             base_we_i,
  input  logic [AW-1:0]    base_val_i,
  input  logic             len_we_i,
  input  logic [LW-1:0]    len_val_i,
  input  logic             rxlen_we_i,
  input  logic [LW-1:0]    rxlen_val_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [AW-1:0]    dma_addr_o,
  output logic [LW-1:0]    remain_o,
  output logic [LW-1:0]    rxlen_o,
  output logic [STS_W-1:0] sts_set_o,
  output logic             buf_set_o,
  output logic [7:0]       buf_val_o
);
  rx_state_e     state_q;
  logic [AW-1:0] dma_addr_q;
  logic [LW-1:0] remain_q, rxlen_q;
  logic          ev_addr, ev_data, ev_stop, ev_start;
  logic          hit, dat, take, drop, pio, fin;

  always_comb begin
    ev_start = ev_valid_i && (ev_kind_i == EV_START);
    ev_addr  = ev_valid_i && (ev_kind_i == EV_ADDR);
    ev_data  = ev_valid_i && (ev_kind_i == EV_DATA);
    ev_stop  = ev_valid_i && (ev_kind_i == EV_STOP);
    hit  = ev_addr && (state_q == ST_WAIT_ADDR) && target_en_i &&
           (ev_data_i[7:1] == own_addr_i) && !ev_data_i[0];
    dat  = ev_data && (state_q == ST_ACTIVE);
    take = dat && dma_en_i && (remain_q != '0);
    drop = dat && dma_en_i && (remain_q == '0);
    pio  = dat && !dma_en_i;
    fin  = ev_stop && (state_q == ST_ACTIVE);
  end

  always_comb begin
    sts_set_o          = '0;
    sts_set_o[B_RX]    = fin;
    sts_set_o[B_STOP]  = fin;
    sts_set_o[B_MATCH] = fin;
    sts_set_o[B_PKT]   = fin;
    sts_set_o[B_BYTE]  = pio || (hit && !dma_en_i);
    sts_set_o[B_OVF]   = drop;
    buf_set_o          = pio || (hit && !dma_en_i);
    buf_val_o          = pio ? ev_data_i : {own_addr_i, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else if (ev_start) begin
      state_q <= ST_WAIT_ADDR;
    end else if (ev_stop) begin
      state_q <= ST_IDLE;
    end else if (ev_addr && state_q == ST_WAIT_ADDR) begin
      state_q <= hit ? ST_ACTIVE : ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_addr_q  <= '0;
      remain_q    <= '0;
      rxlen_q     <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= take;
      if (take) begin
        mem_addr_o  <= dma_addr_q;
        mem_wdata_o <= ev_data_i;
      end
      if (base_we_i)   dma_addr_q <= base_val_i;
      else if (take)   dma_addr_q <= dma_addr_q + AW'(1);
      if (len_we_i)    remain_q   <= len_val_i;
      else if (take)   remain_q   <= remain_q - LW'(1);
      if (rxlen_we_i)  rxlen_q    <= rxlen_val_i;
      else if (hit)    rxlen_q    <= '0;
      else if (take)   rxlen_q    <= rxlen_q + LW'(1);
    end
  end

  assign dma_addr_o = dma_addr_q;
  assign remain_o   = remain_q;
  assign rxlen_o    = rxlen_q;

  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !$past(base_we_i)) |-> (dma_addr_q == mem_addr_o + AW'(1))); // R4
  AST_DROP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_data && remain_q == '0) |=> !mem_we_o); // R5
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ACTIVE) |=> !mem_we_o); // R2
  AST_RXLEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !rxlen_we_i) |=> (rxlen_q == '0)); // R3
endmodule

// File: rtl/tgt_rx_regs.sv
module tgt_rx_regs
  import tgt_rx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int MW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [MW-1:0]    mst_set_i,
  input  logic [STS_W-1:0] sts_set_i,
  input  logic             buf_set_i,
  input  logic [7:0]       buf_val_i,
  input  logic [AW-1:0]    dma_addr_i,
  input  logic [LW-1:0]    remain_i,
  input  logic [LW-1:0]    rxlen_i,
  output logic             target_en_o,
  output logic             dma_en_o,
  output logic [6:0]       own_addr_o,
  output logic             base_we_o,
  output logic             len_we_o,
  output logic             rxlen_we_o,
  output logic [STS_W-1:0] tsts_o,
  output logic [STS_W-1:0] tien_o,
  output logic [MW-1:0]    msts_o,
  output logic [MW-1:0]    mien_o
);
  logic             master_en_q, target_en_q, dma_en_q;
  logic [6:0]       own_q;
  logic [STS_W-1:0] tsts_q, tien_q, tclr;
  logic [MW-1:0]    msts_q, mien_q, mclr;
  logic [7:0]       buf_q;

  function automatic logic wr(input logic [3:0] idx);
    return reg_we_i && (reg_addr_i == idx);
  endfunction

  always_comb begin
    tclr = '0;
    mclr = '0;
    if (wr(RI_TSTS)) begin
      tclr = reg_wdata_i[STS_W-1:0];
      // packet bit sweeps itself and everything beneath it
      if (reg_wdata_i[B_PKT]) tclr[B_PKT:0] = '1;
    end
    if (wr(RI_MSTS)) mclr = reg_wdata_i[MW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_en_q <= 1'b0;
      target_en_q <= 1'b0;
      dma_en_q    <= 1'b0;
      own_q       <= '0;
      tsts_q      <= '0;
      tien_q      <= '0;
      msts_q      <= '0;
      mien_q      <= '0;
      buf_q       <= '0;
    end else begin
      if (wr(RI_FUNC)) {target_en_q, master_en_q} <= reg_wdata_i[1:0];
      if (wr(RI_OWN))  own_q    <= reg_wdata_i[6:0];
      if (wr(RI_CMD))  dma_en_q <= reg_wdata_i[0];
      if (wr(RI_TIEN)) tien_q   <= reg_wdata_i[STS_W-1:0];
      if (wr(RI_MIEN)) mien_q   <= reg_wdata_i[MW-1:0];
      if (buf_set_i)   buf_q    <= buf_val_i;
      tsts_q <= (tsts_q & ~tclr) | sts_set_i;
      msts_q <= (msts_q & ~mclr) | (master_en_q ? mst_set_i : '0);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RI_FUNC: reg_rdata_o = {30'd0, target_en_q, master_en_q};
      RI_OWN:  reg_rdata_o = 32'(own_q);
      RI_CMD:  reg_rdata_o = 32'(dma_en_q);
      RI_BASE: reg_rdata_o = 32'(dma_addr_i);
      RI_LEN:  reg_rdata_o = (32'(rxlen_i) << LEN_HI_LSB) | 32'(remain_i);
      RI_TSTS: reg_rdata_o = 32'(tsts_q);
      RI_TIEN: reg_rdata_o = 32'(tien_q);
      RI_MSTS: reg_rdata_o = 32'(msts_q);
      RI_MIEN: reg_rdata_o = 32'(mien_q);
      RI_BUF:  reg_rdata_o = 32'(buf_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign target_en_o = target_en_q;
  assign dma_en_o    = dma_en_q;
  assign own_addr_o  = own_q;
  assign base_we_o   = wr(RI_BASE);
  assign len_we_o    = wr(RI_LEN);
  assign rxlen_we_o  = wr(RI_LEN) && reg_wdata_i[LEN_WE_BIT];
  assign tsts_o      = tsts_q;
  assign tien_o      = tien_q;
  assign msts_o      = msts_q;
  assign mien_o      = mien_q;

  AST_PKT_KEEP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr(RI_TSTS) && reg_wdata_i[B_PKT] && !reg_wdata_i[B_OVF] && !sts_set_i[B_OVF])
    |=> (tsts_q[B_OVF] == $past(tsts_q[B_OVF]))); // R7
  AST_DONE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsts_q[B_PKT]) |-> (tsts_q[B_MATCH] && tsts_q[B_STOP] && tsts_q[B_RX])); // R6
  AST_MST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_q |=> ((msts_q & ~$past(msts_q)) == '0)); // R11
endmodule

// File: rtl/tgt_rx_irq.sv
module tgt_rx_irq #(
  parameter int TW = 6,
  parameter int MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tsts_i,
  input  logic [TW-1:0] tien_i,
  input  logic [MW-1:0] msts_i,
  input  logic [MW-1:0] mien_i,
  output logic          irq_o
);
  logic pend;
  // either side holding enabled status keeps the shared line asserted
  assign pend = |(tsts_i & tien_i) || |(msts_i & mien_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend;
  end

  AST_IRQ_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> irq_o); // R10
  AST_IRQ_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> !irq_o); // R10
endmodule

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma
  import tgt_rx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int MW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          ev_valid_i,
  input  logic [1:0]    ev_kind_i,
  input  logic [7:0]    ev_data_i,
  input  logic [MW-1:0] mst_set_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          irq_o
);
  logic             target_en, dma_en, base_we, len_we, rxlen_we, buf_set;
  logic [6:0]       own_addr;
  logic [7:0]       buf_val;
  logic [AW-1:0]    dma_addr;
  logic [LW-1:0]    remain, rxlen;
  logic [STS_W-1:0] sts_set, tsts, tien;
  logic [MW-1:0]    msts, mien;

  tgt_rx_regs #(.AW(AW), .LW(LW), .MW(MW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mst_set_i,
    .sts_set_i   (sts_set),
    .buf_set_i   (buf_set),
    .buf_val_i   (buf_val),
    .dma_addr_i  (dma_addr),
    .remain_i    (remain),
    .rxlen_i     (rxlen),
    .target_en_o (target_en),
    .dma_en_o    (dma_en),
    .own_addr_o  (own_addr),
    .base_we_o   (base_we),
    .len_we_o    (len_we),
    .rxlen_we_o  (rxlen_we),
    .tsts_o      (tsts),
    .tien_o      (tien),
    .msts_o      (msts),
    .mien_o      (mien)
  );

  tgt_rx_dma #(.AW(AW), .LW(LW)) u_dma (
    .clk_i, .rst_ni, .ev_valid_i, .ev_kind_i, .ev_data_i,
    .target_en_i (target_en),
    .dma_en_i    (dma_en),
    .own_addr_i  (own_addr),
    .base_we_i   (base_we),
    .base_val_i  (reg_wdata_i[AW-1:0]),
    .len_we_i    (len_we),
    .len_val_i   (reg_wdata_i[LW-1:0]),
    .rxlen_we_i  (rxlen_we),
    .rxlen_val_i (reg_wdata_i[LEN_HI_LSB +: LW]),
    .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .dma_addr_o  (dma_addr),
    .remain_o    (remain),
    .rxlen_o     (rxlen),
    .sts_set_o   (sts_set),
    .buf_set_o   (buf_set),
    .buf_val_o   (buf_val)
  );

  tgt_rx_irq #(.TW(STS_W), .MW(MW)) u_irq (
    .clk_i, .rst_ni,
    .tsts_i (tsts),
    .tien_i (tien),
    .msts_i (msts),
    .mien_i (mien),
    .irq_o
  );
endmodule

// File: tb/sim_i2c_tgt_rx_dma.sv
`timescale 1ns/1ps
module sim_i2c_tgt_rx_dma;
  localparam logic [3:0] I_FUNC = 0, I_OWN = 1, I_CMD = 2, I_BASE = 3, I_LEN = 4,
                         I_TSTS = 5, I_TIEN = 6, I_MSTS = 7, I_MIEN = 8, I_BUF = 9;
  localparam logic [1:0] K_START = 0, K_ADDR = 1, K_DATA = 2, K_STOP = 3;

  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        ev_valid_i = 0;
  logic [1:0]  ev_kind_i = 0;
  logic [7:0]  ev_data_i = 0;
  logic [3:0]  mst_set_i = 0;
  logic        mem_we_o, irq_o;
  logic [7:0]  mem_addr_o, mem_wdata_o;

  int checks = 0, errors = 0, nwr = 0;
  logic [7:0] bmem [256];
  bit done = 0;

  i2c_tgt_rx_dma u0 (.*);

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i)
    if (rst_ni && mem_we_o) begin
      bmem[mem_addr_o] = mem_wdata_o;
      nwr++;
    end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk_i);
    ev_valid_i = 1; ev_kind_i = k; ev_data_i = d;
    @(negedge clk_i);
    ev_valid_i = 0;
  endtask

  task automatic settle;
    repeat (2) @(negedge clk_i);
    #1;
  endtask

  task automatic mpulse(input logic [3:0] m);
    @(negedge clk_i);
    mst_set_i = m;
    @(negedge clk_i);
    mst_set_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    rreg(I_TSTS, v); chk("R1 tsts", v, 0);
    rreg(I_LEN, v);  chk("R1 len", v, 0);
    rreg(I_BUF, v);  chk("R1 buf", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 mem_we", mem_we_o, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wreg(I_FUNC, 2); wreg(I_OWN, 32'h2A); wreg(I_CMD, 1);
    wreg(I_BASE, 32'h40); wreg(I_LEN, 32'h0000_0010); wreg(I_TIEN, 32'h10);
    ev(K_START, 0); ev(K_ADDR, 8'h54);
    ev(K_DATA, 8'hA1); ev(K_DATA, 8'hB2); ev(K_DATA, 8'hC3);
    ev(K_STOP, 0);
    settle;
    chk("R4 writes", nwr, 3);
    chk("R4 mem40", bmem[8'h40], 8'hA1);
    chk("R4 mem41", bmem[8'h41], 8'hB2);
    chk("R4 mem42", bmem[8'h42], 8'hC3);
    rreg(I_LEN, v);  chk("R4 len", v, 32'h0003_000D);
    rreg(I_BASE, v); chk("R4 addr ctr", v, 32'h43);
    rreg(I_TSTS, v); chk("R6 group", v, 32'h17);
    chk("R10 irq up", irq_o, 1);
  endtask

  task automatic t_overflow_clear;
    logic [31:0] v;
    wreg(I_BASE, 32'h80); wreg(I_LEN, 32'h0000_0001);
    ev(K_START, 0); ev(K_ADDR, 8'h54);
    ev(K_DATA, 8'h11); ev(K_DATA, 8'h22); ev(K_STOP, 0);
    settle;
    chk("R5 one write", nwr, 4);
    chk("R5 mem80", bmem[8'h80], 8'h11);
    rreg(I_LEN, v);  chk("R3 rxlen zeroed", v, 32'h0001_0000);
    rreg(I_TSTS, v); chk("R5 overflow", v, 32'h37);
    wreg(I_TSTS, 32'h10); #1;
    rreg(I_TSTS, v); chk("R7 pkt clear", v, 32'h20);
    wreg(I_TSTS, 32'h20); #1;
    rreg(I_TSTS, v); chk("R7 ovf clear", v, 0);
    settle;
    chk("R10 irq down", irq_o, 0);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    wreg(I_LEN, 32'h0000_0008); wreg(I_BASE, 32'h90);
    ev(K_START, 0); ev(K_ADDR, 8'h56); ev(K_DATA, 8'h33); ev(K_STOP, 0);
    ev(K_START, 0); ev(K_ADDR, 8'h55); ev(K_DATA, 8'h44); ev(K_STOP, 0);
    settle;
    chk("R2 no writes", nwr, 4);
    rreg(I_TSTS, v); chk("R2 no status", v, 0);
    rreg(I_LEN, v);  chk("R2 len kept", v, 32'h0001_0008);
    wreg(I_FUNC, 0);
    ev(K_START, 0); ev(K_ADDR, 8'h54); ev(K_DATA, 8'h66); ev(K_STOP, 0);
    settle;
    chk("R12 disabled no write", nwr, 4);
    rreg(I_TSTS, v); chk("R12 disabled no status", v, 0);
    wreg(I_FUNC, 2);
  endtask

  task automatic t_lenwe;
    logic [31:0] v;
    wreg(I_LEN, 32'h0005_0020); #1;
    rreg(I_LEN, v); chk("R8 no we", v, 32'h0001_0020);
    wreg(I_LEN, 32'h8007_0020); #1;
    rreg(I_LEN, v); chk("R8 we", v, 32'h0007_0020);
  endtask

  task automatic t_pio;
    logic [31:0] v;
    wreg(I_CMD, 0);
    ev(K_START, 0); ev(K_ADDR, 8'h54);
    settle;
    rreg(I_BUF, v);  chk("R9 addr byte", v, 32'h54);
    rreg(I_TSTS, v); chk("R9 byte flag", v, 32'h08);
    ev(K_DATA, 8'h9C);
    settle;
    rreg(I_BUF, v);  chk("R9 data byte", v, 32'h9C);
    ev(K_STOP, 0);
    settle;
    rreg(I_TSTS, v); chk("R9 stop sts", v, 32'h1F);
    chk("R9 no mem", nwr, 4);
    wreg(I_TSTS, 32'h10); #1;
    rreg(I_TSTS, v); chk("R7 clear below", v, 0);
    wreg(I_CMD, 1);
  endtask

  task automatic xfer(input logic [7:0] d);
    ev(K_START, 0); ev(K_ADDR, 8'h54); ev(K_DATA, d); ev(K_STOP, 0);
  endtask

  task automatic t_irq_shared;
    logic [31:0] v;
    wreg(I_FUNC, 3); wreg(I_BASE, 32'h10); wreg(I_LEN, 32'h20);
    wreg(I_MIEN, 1); wreg(I_TIEN, 32'h10);
    mpulse(4'h1);
    settle;
    rreg(I_MSTS, v); chk("R11 set", v, 1);
    chk("R10 master irq", irq_o, 1);
    xfer(8'h77);
    settle;
    chk("R4 mem10", bmem[8'h10], 8'h77);
    wreg(I_MSTS, 1);
    settle;
    rreg(I_MSTS, v); chk("R11 w1c", v, 0);
    chk("R10 held by target", irq_o, 1);
    wreg(I_TSTS, 32'h10);
    settle;
    chk("R10 both clear", irq_o, 0);
    xfer(8'h78);
    mpulse(4'h1);
    wreg(I_TSTS, 32'h10);
    settle;
    chk("R10 held by master", irq_o, 1);
    wreg(I_MSTS, 1);
    settle;
    chk("R10 low again", irq_o, 0);
    wreg(I_FUNC, 2);
    mpulse(4'h1);
    settle;
    rreg(I_MSTS, v); chk("R11 gated", v, 0);
    chk("R11 irq stays low", irq_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1;
    t_basic;
    t_overflow_clear;
    t_ignore;
    t_lenwe;
    t_pio;
    t_irq_shared;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule